// File: doc/BRIEF.md
# Pseudo-SRAM Self-Refresh and Power-State Controller

This block sits inside a pseudo-static RAM model and decides when the DRAM core gets a row refresh and which power state the part is in. A free-running timebase tick paces everything. The block issues refresh requests at a fixed tick interval. Each request carries a row address that stays inside a selectable slice of the array. That slice is the whole array, a half, a quarter, an eighth or nothing, and it is anchored at either the bottom or the top of the row space. A request stays raised until the core acknowledges it. The row counter moves forward only on that acknowledge.

The controller has four states. ACTIVE (code 0) is an access in progress. STANDBY (code 1) is the low-power wait. DEEP (code 2) is deep power-down, where refresh stops. INIT (code 3) is the wake-up initialization. The named transitions are:

- reset-to-INIT.
- INIT-done: INIT to STANDBY.
- access-start: STANDBY to ACTIVE.
- access-end: ACTIVE to STANDBY.
- idle-timeout: ACTIVE to STANDBY.
- deselect: ACTIVE to STANDBY on a chip-enable rise.
- power-down: ACTIVE or STANDBY to DEEP.
- wake: DEEP to INIT.

A decoded register field arms deep power-down, and the state is entered on the next rise of the active-low chip enable. To leave DEEP, the chip enable must be held low for a tick count. A second tick count of initialization then follows before the ready flag returns.

Top module: `psram_pwr_ctrl`

## Requirements
- R1: While reset is held, and right after it is released, pwr_state is INIT (3), ready is low and ref_req is low.
- R2: The coverage field cov_sel selects the refreshed region size as ROWS>>cov_sel: 0 is the full array, 1 is a half, 2 is a quarter and 3 is an eighth, where ROWS = 2**ROW_W.
- R3: With anchor_top = 0 the region starts at row 0. With anchor_top = 1 it ends at row ROWS-1. Every row presented with ref_req lies inside the region.
- R4: Each acknowledged request moves the row offset forward by one, wrapping to the start of the region after its last row. An unacknowledged request keeps the same row.
- R5: When the region is widened, the next presented row is computed with the new size, with no added delay.
- R6: A request is raised every REF_INTERVAL ticks while refresh runs. Once raised, it stays high until ref_ack is sampled high.
- R7: cov_sel values 4 to 7 select no rows. No request is raised, and the state does not become DEEP.
- R8: With chip enable high, ACTIVE and STANDBY go to STANDBY. STANDBY goes to ACTIVE on bus_change while chip enable is low. ACTIVE goes to STANDBY on access_done, or after IDLE_TICKS ticks with no bus_change.
- R9: Deep power-down is entered only on a rise of ce_n while dpd_arm is high. Arming alone does not change the state.
- R10: In DEEP, ref_req stays low and ready is low.
- R11: DEEP is left for INIT only after ce_n has been low for EXIT_TICKS consecutive ticks. A shorter low pulse leaves the state at DEEP.
- R12: INIT lasts exactly INIT_TICKS ticks and then goes to STANDBY with ready high. Refresh resumes after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase tick, one cycle wide |
| ce_n | input | 1 | Active-low chip enable |
| bus_change | input | 1 | Pulse when the address or control inputs change |
| access_done | input | 1 | Pulse when a read or write completes |
| dpd_arm | input | 1 | Decoded deep power-down arm field |
| cov_sel | input | 3 | Decoded refresh coverage field |
| anchor_top | input | 1 | Decoded region anchor: 0 bottom, 1 top |
| ref_ack | input | 1 | Core acknowledge of the current refresh request |
| ref_req | output | 1 | Refresh request |
| ref_row | output | ROW_W | Row to refresh |
| ready | output | 1 | Accesses accepted (ACTIVE or STANDBY) |
| pwr_state | output | 2 | Current state code |

## Verification
The bench builds the controller with ROW_W=4 (16 rows), REF_INTERVAL=4, EXIT_TICKS=5, INIT_TICKS=12 and IDLE_TICKS=20, and holds tick high on every cycle. These small values let one run reach several things: full-array wraparound, eighth-size regions at both ends, and a widening step partway through a sequence. They also make the exact durations of INIT, the DEEP exit window and the idle timeout short enough to count edge by edge.

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;

    typedef enum logic [1:0] {
        PS_ACTIVE  = 2'd0,
        PS_STANDBY = 2'd1,
        PS_DEEP    = 2'd2,
        PS_INIT    = 2'd3
    } pwr_state_t;

    localparam int COV_W = 3;

    // States in which accesses are accepted and refresh runs
    function automatic logic is_awake(pwr_state_t s);
        return (s == PS_ACTIVE) || (s == PS_STANDBY);
    endfunction

endpackage

// File: rtl/psram_region_map.sv
module psram_region_map
    import psram_pwr_pkg::*;
#(
    parameter int ROW_W = 12
) (
    input  logic [COV_W-1:0] cov_sel,
    input  logic             anchor_top,
    output logic [ROW_W-1:0] base,
    output logic [ROW_W-1:0] mask,
    output logic             region_on
);
    localparam logic [ROW_W-1:0] FULL_MASK = {ROW_W{1'b1}};

    always_comb begin
        // region size = ROWS >> cov_sel[1:0]; mask = size - 1
        mask      = FULL_MASK >> cov_sel[1:0];
        // a top-anchored region starts at ROWS - size, which is ~mask
        base      = anchor_top ? ~mask : '0;
        region_on = ~cov_sel[2];
    end
endmodule

// File: rtl/psram_refresh_gen.sv
module psram_refresh_gen #(
    parameter int ROW_W        = 12,
    parameter int REF_INTERVAL = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run_d,
    input  logic             region_on,
    input  logic [ROW_W-1:0] base,
    input  logic [ROW_W-1:0] mask,
    input  logic             ref_ack,
    output logic             ref_req,
    output logic [ROW_W-1:0] ref_row
);
    localparam int CNT_W = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REF_INTERVAL - 1);

    logic [CNT_W-1:0] gap_q;
    logic             req_q;
    logic [ROW_W-1:0] off_q;
    logic [ROW_W-1:0] off_cur;

    // Offset is masked where it is used, so a wider region applies at once
    assign off_cur = off_q & mask;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
            req_q <= 1'b0;
            off_q <= '0;
        end else if (!run_d || !region_on) begin
            gap_q <= '0;
            req_q <= 1'b0;
        end else begin
            if (req_q && ref_ack) begin
                req_q <= 1'b0;
                off_q <= (off_cur + 1'b1) & mask;
            end
            if (tick) begin
                if (gap_q == CNT_LAST) begin
                    gap_q <= '0;
                    req_q <= 1'b1;
                end else begin
                    gap_q <= gap_q + 1'b1;
                end
            end
        end
    end

    assign ref_req = req_q;
    assign ref_row = base | off_cur;
endmodule

// File: rtl/psram_pwr_fsm.sv
module psram_pwr_fsm
    import psram_pwr_pkg::*;
#(
    parameter int EXIT_TICKS = 10,
    parameter int INIT_TICKS = 150,
    parameter int IDLE_TICKS = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       ce_n,
    input  logic       bus_change,
    input  logic       access_done,
    input  logic       dpd_arm,
    output pwr_state_t state,
    output logic       ready,
    output logic       run_d
);
    localparam int T_MAX0 = (EXIT_TICKS > INIT_TICKS) ? EXIT_TICKS : INIT_TICKS;
    localparam int T_MAX  = (T_MAX0 > IDLE_TICKS) ? T_MAX0 : IDLE_TICKS;
    localparam int TMR_W  = $clog2(T_MAX + 1);
    localparam logic [TMR_W-1:0] EXIT_LAST = TMR_W'(EXIT_TICKS - 1);
    localparam logic [TMR_W-1:0] INIT_LAST = TMR_W'(INIT_TICKS - 1);
    localparam logic [TMR_W-1:0] IDLE_LAST = TMR_W'(IDLE_TICKS - 1);

    pwr_state_t       state_q, state_d;
    logic [TMR_W-1:0] tmr_q;
    logic             tmr_clr, tmr_inc;
    logic             ce_q;
    logic             ce_rise;

    assign ce_rise = ce_n & ~ce_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_INIT;
            ce_q    <= 1'b1;
        end else begin
            state_q <= state_d;
            ce_q    <= ce_n;
        end
    end

    // Shared timer: exit window, init delay and idle timeout never overlap
    always_ff @(posedge clk) begin
        if (!rst_n || tmr_clr) tmr_q <= '0;
        else if (tmr_inc)      tmr_q <= tmr_q + 1'b1;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        tmr_clr = 1'b0;
        tmr_inc = 1'b0;
        unique case (state_q)
            PS_INIT: begin
                if (tick) begin
                    if (tmr_q == INIT_LAST) begin
                        state_d = PS_STANDBY;
                        tmr_clr = 1'b1;
                    end else begin
                        tmr_inc = 1'b1;
                    end
                end
            end
            PS_DEEP: begin
                if (ce_n) begin
                    tmr_clr = 1'b1;
                end else if (tick) begin
                    if (tmr_q == EXIT_LAST) begin
                        state_d = PS_INIT;
                        tmr_clr = 1'b1;
                    end else begin
                        tmr_inc = 1'b1;
                    end
                end
            end
            PS_STANDBY: begin
                tmr_clr = 1'b1;
                if (ce_rise && dpd_arm)        state_d = PS_DEEP;
                else if (!ce_n && bus_change)  state_d = PS_ACTIVE;
            end
            PS_ACTIVE: begin
                if (ce_rise && dpd_arm) begin
                    state_d = PS_DEEP;
                    tmr_clr = 1'b1;
                end else if (ce_n || access_done) begin
                    state_d = PS_STANDBY;
                    tmr_clr = 1'b1;
                end else if (bus_change) begin
                    tmr_clr = 1'b1;
                end else if (tick) begin
                    if (tmr_q == IDLE_LAST) begin
                        state_d = PS_STANDBY;
                        tmr_clr = 1'b1;
                    end else begin
                        tmr_inc = 1'b1;
                    end
                end
            end
            default: begin
                state_d = PS_INIT;
                tmr_clr = 1'b1;
            end
        endcase
    end

    // Outputs
    always_comb begin
        state = state_q;
        ready = is_awake(state_q);
        run_d = is_awake(state_d);
    end
endmodule

// File: rtl/psram_pwr_ctrl.sv
module psram_pwr_ctrl
    import psram_pwr_pkg::*;
#(
    parameter int ROW_W        = 12,
    parameter int REF_INTERVAL = 64,
    parameter int EXIT_TICKS   = 10,
    parameter int INIT_TICKS   = 150,
    parameter int IDLE_TICKS   = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ce_n,
    input  logic             bus_change,
    input  logic             access_done,
    input  logic             dpd_arm,
    input  logic [2:0]       cov_sel,
    input  logic             anchor_top,
    input  logic             ref_ack,
    output logic             ref_req,
    output logic [ROW_W-1:0] ref_row,
    output logic             ready,
    output logic [1:0]       pwr_state
);
    pwr_state_t       st;
    logic             run_d;
    logic [ROW_W-1:0] base, mask;
    logic             region_on;

    psram_pwr_fsm #(
        .EXIT_TICKS(EXIT_TICKS),
        .INIT_TICKS(INIT_TICKS),
        .IDLE_TICKS(IDLE_TICKS)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ce_n(ce_n),
        .bus_change(bus_change), .access_done(access_done), .dpd_arm(dpd_arm),
        .state(st), .ready(ready), .run_d(run_d)
    );

    psram_region_map #(.ROW_W(ROW_W)) u_map (
        .cov_sel(cov_sel), .anchor_top(anchor_top),
        .base(base), .mask(mask), .region_on(region_on)
    );

    psram_refresh_gen #(
        .ROW_W(ROW_W),
        .REF_INTERVAL(REF_INTERVAL)
    ) u_ref (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run_d(run_d),
        .region_on(region_on), .base(base), .mask(mask),
        .ref_ack(ref_ack), .ref_req(ref_req), .ref_row(ref_row)
    );

    assign pwr_state = st;
endmodule

// File: rtl/psram_pwr_ctrl_chk.sv
module psram_pwr_ctrl_chk #(
    parameter int ROW_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce_n,
    input logic             dpd_arm,
    input logic [2:0]       cov_sel,
    input logic             anchor_top,
    input logic             ref_ack,
    input logic             ref_req,
    input logic [ROW_W-1:0] ref_row,
    input logic             ready,
    input logic [1:0]       pwr_state
);
    localparam int ROWS = 1 << ROW_W;

    function automatic logic row_inside(logic [ROW_W-1:0] r, logic [1:0] c, logic top);
        int sz;
        int lo;
        sz = ROWS >> c;
        lo = top ? (ROWS - sz) : 0;
        return (int'(r) >= lo) && (int'(r) < lo + sz);
    endfunction

    p_row_in_region_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> row_inside(ref_row, cov_sel[1:0], anchor_top));

    p_req_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !ref_ack && !cov_sel[2]) |=> (ref_req || !ready));

    p_none_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cov_sel[2] |=> !ref_req);

    p_deselect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && ready) |=> (pwr_state == 2'd1 || pwr_state == 2'd2));

    p_dpd_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_state == 2'd2) |-> ($past(dpd_arm) && $past(ce_n)));

    p_deep_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd2) |-> (!ref_req && !ready));

    p_deep_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd2 && ce_n) |=> (pwr_state == 2'd2));
endmodule

bind psram_pwr_ctrl psram_pwr_ctrl_chk #(.ROW_W(ROW_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .dpd_arm(dpd_arm),
    .cov_sel(cov_sel), .anchor_top(anchor_top), .ref_ack(ref_ack),
    .ref_req(ref_req), .ref_row(ref_row), .ready(ready), .pwr_state(pwr_state)
);

// File: tb/psram_pwr_ctrl_test.sv
module psram_pwr_ctrl_test;
    localparam int ROW_W = 4;
    localparam int ROWS  = 1 << ROW_W;
    localparam int REF_INTERVAL = 4;
    localparam int EXIT_TICKS = 5;
    localparam int INIT_TICKS = 12;
    localparam int IDLE_TICKS = 20;

    logic clk = 1'b0;
    logic rst_n, tick, ce_n, bus_change, access_done, dpd_arm, anchor_top, ref_ack;
    logic [2:0] cov_sel;
    logic ref_req, ready;
    logic [ROW_W-1:0] ref_row;
    logic [1:0] pwr_state;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    int m_off = 0;
    int last_rise = 0;
    int prev_rise = 0;
    bit ack_en = 0;
    bit done = 0;
    int    exp_q[$];
    string tag_q[$];

    psram_pwr_ctrl #(
        .ROW_W(ROW_W), .REF_INTERVAL(REF_INTERVAL), .EXIT_TICKS(EXIT_TICKS),
        .INIT_TICKS(INIT_TICKS), .IDLE_TICKS(IDLE_TICKS)
    ) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ce_n(ce_n),
        .bus_change(bus_change), .access_done(access_done), .dpd_arm(dpd_arm),
        .cov_sel(cov_sel), .anchor_top(anchor_top), .ref_ack(ref_ack),
        .ref_req(ref_req), .ref_row(ref_row), .ready(ready), .pwr_state(pwr_state)
    );

    always #5 clk = ~clk;

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    task automatic check_eq(string req, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d (cycle %0d)", req, got, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Reference model of the region walk, taken from R2 to R4
    function automatic int model_row(int cov, int top);
        int sz;
        int lo;
        int o;
        sz = ROWS >> cov;
        lo = top ? ROWS - sz : 0;
        o = m_off % sz;
        m_off = (o + 1) % sz;
        return lo + o;
    endfunction

    // Monitor: acknowledges requests and compares rows against the scoreboard
    initial begin
        ref_ack = 0;
        forever begin
            @(negedge clk);
            #1;
            if (ref_req && (last_rise == 0 || ref_ack == 0) && !$isunknown(ref_req)) begin end
            if (ref_ack) begin
                ref_ack = 0;
            end else if (ref_req && ack_en && exp_q.size() > 0) begin
                check_eq(tag_q.pop_front(), int'(ref_row), exp_q.pop_front());
                ref_ack = 1;
            end
        end
    end

    // Rise tracker for the request interval
    initial begin
        logic prev;
        prev = 0;
        forever begin
            @(negedge clk);
            #1;
            if (ref_req && !prev) begin
                prev_rise = last_rise;
                last_rise = cyc;
            end
            prev = ref_req;
        end
    end

    // Driver: pushes expected rows and waits for them to drain
    task automatic run_batch(int cov, int top, int n, string tag);
        int guard;
        @(negedge clk);
        cov_sel = 3'(cov);
        anchor_top = top[0];
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(model_row(cov, top));
            tag_q.push_back(tag);
        end
        guard = 0;
        while (exp_q.size() > 0 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        check_eq({tag, " drained"}, exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
        repeat (2) @(negedge clk);
    endtask

    task automatic expect_quiet(int n, string tag);
        int seen;
        seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
            if (ref_req) seen++;
        end
        check_eq(tag, seen, 0);
    endtask

    task automatic sample();
        @(negedge clk);
        #1;
    endtask

    task automatic count_init(output int n);
        n = 0;
        while (pwr_state == 2'd3 && n < 1000) begin
            n++;
            sample();
        end
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
        finish_run();
    end

    initial begin
        int n;
        int row0;
        rst_n = 0; tick = 1; ce_n = 1; bus_change = 0; access_done = 0;
        dpd_arm = 0; cov_sel = 3'd0; anchor_top = 0;
        repeat (3) @(negedge clk);
        #1;
        check_eq("R1 state in reset", int'(pwr_state), 3);
        @(negedge clk);
        rst_n = 1;
        #1;
        check_eq("R1 state after reset", int'(pwr_state), 3);
        check_eq("R1 ready after reset", int'(ready), 0);
        check_eq("R1 req after reset", int'(ref_req), 0);
        count_init(n);
        check_eq("R12 power-up INIT length", n, INIT_TICKS);
        check_eq("R12 ready after INIT", int'(ready), 1);
        check_eq("R12 STANDBY after INIT", int'(pwr_state), 1);

        // Refresh sequences
        ack_en = 1;
        run_batch(0, 0, 18, "R4 full array wrap");
        check_eq("R6 request interval", last_rise - prev_rise, REF_INTERVAL);
        run_batch(1, 1, 10, "R3 half top");
        run_batch(3, 0, 5, "R2 eighth bottom");
        run_batch(3, 1, 3, "R3 eighth top");
        run_batch(3, 0, 3, "R2 eighth before widen");
        run_batch(2, 0, 4, "R5 widened quarter");
        run_batch(2, 1, 5, "R3 quarter top");

        // Hold without acknowledge
        ack_en = 0;
        @(negedge clk);
        cov_sel = 3'd0; anchor_top = 0;
        repeat (REF_INTERVAL + 3) sample();
        check_eq("R6 request raised", int'(ref_req), 1);
        row0 = int'(ref_row);
        repeat (10) sample();
        check_eq("R6 request held", int'(ref_req), 1);
        check_eq("R4 row held while pending", int'(ref_row), row0);
        ack_en = 1;
        run_batch(0, 0, 3, "R4 resume after hold");

        // No rows selected
        @(negedge clk);
        cov_sel = 3'd4;
        sample();
        expect_quiet(40, "R7 no requests with no rows");
        check_eq("R7 not in DEEP", int'(pwr_state == 2'd2), 0);

        // Standby / active transitions
        @(negedge clk);
        ce_n = 0;
        repeat (3) sample();
        check_eq("R8 low ce alone stays STANDBY", int'(pwr_state), 1);
        @(negedge clk); bus_change = 1;
        @(negedge clk); bus_change = 0; #1;
        check_eq("R8 access-start", int'(pwr_state), 0);
        @(negedge clk); access_done = 1;
        @(negedge clk); access_done = 0; #1;
        check_eq("R8 access-end", int'(pwr_state), 1);
        @(negedge clk); bus_change = 1;
        @(negedge clk); bus_change = 0; #1;
        repeat (IDLE_TICKS - 2) sample();
        check_eq("R8 idle not yet expired", int'(pwr_state), 0);
        repeat (3) sample();
        check_eq("R8 idle-timeout", int'(pwr_state), 1);
        @(negedge clk); bus_change = 1;
        @(negedge clk); bus_change = 0; ce_n = 1; #1;
        sample();
        check_eq("R8 deselect", int'(pwr_state), 1);

        // Deep power-down
        ack_en = 0;
        @(negedge clk); ce_n = 0; cov_sel = 3'd0; bus_change = 1;
        @(negedge clk); bus_change = 0; dpd_arm = 1; #1;
        repeat (3) sample();
        check_eq("R9 armed but no ce rise", int'(pwr_state), 0);
        @(negedge clk); ce_n = 1; #1;
        sample();
        check_eq("R9 power-down on ce rise", int'(pwr_state), 2);
        check_eq("R10 ready low in DEEP", int'(ready), 0);
        dpd_arm = 0;
        expect_quiet(30, "R10 no requests in DEEP");
        @(negedge clk); ce_n = 0;
        repeat (EXIT_TICKS - 1) @(negedge clk);
        ce_n = 1; #1;
        check_eq("R11 short pulse stays DEEP", int'(pwr_state), 2);
        repeat (3) sample();
        check_eq("R11 still DEEP after short pulse", int'(pwr_state), 2);
        @(negedge clk); ce_n = 0; #1;
        repeat (EXIT_TICKS - 1) sample();
        check_eq("R11 DEEP before window ends", int'(pwr_state), 2);
        sample();
        check_eq("R11 wake to INIT", int'(pwr_state), 3);
        check_eq("R12 ready low in INIT", int'(ready), 0);
        count_init(n);
        check_eq("R12 wake INIT length", n, INIT_TICKS);
        check_eq("R12 ready after wake", int'(ready), 1);
        check_eq("R12 STANDBY after wake", int'(pwr_state), 1);
        ack_en = 1;
        run_batch(0, 0, 3, "R12 refresh resumes");

        finish_run();
    end
endmodule